// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that gives a host access to a 512-byte store of configuration registers. SCL and SDA are sampled with the system clock through two-stage synchronizers. START and STOP conditions are found from the synchronized lines. The target drives no tri-state pad: it raises `sda_oe` when the SDA pad has to be pulled low.

The first byte after a START is the slave byte. It is checked against a fixed device type and two strap pins. It also carries the top bit of the register address and the direction bit. A write uses one more byte for the low address bits and one data byte. The data reaches the store only when the host sends a STOP, and that STOP starts a timed write cycle. During the write cycle the target ignores the bus completely, so the host keeps trying until it gets an acknowledge. A read returns bytes from an address pointer that steps forward by one for each byte sent. The read continues for as long as the host acknowledges.

Top module: `i2c_cfg_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and it aborts any transfer in progress, including a repeated START. A rising SDA while SCL is high is a STOP, and it returns the target to idle.
- R2: The slave byte is sent MSB first. Bits 7..4 must equal `DEV_TYPE` (default 4'b1001) and bits 3..2 must equal `bus_strap[1:0]`. When they match, the target acknowledges by pulling SDA low in the ninth clock. When they do not match, there is no acknowledge, and the target ignores every following bit until the next START or STOP.
- R3: In a write, bit 0 of the slave byte is 0 and bit 1 is register-address bit 8. The second byte gives address bits 7..0 and the third byte is the data. The target acknowledges each byte. The register at that 9-bit address takes the data when the STOP arrives.
- R4: No register changes and no write cycle starts in three cases: a STOP before the data byte has been acknowledged, a STOP in the middle of a byte, or a repeated START after the data byte.
- R5: A committing STOP raises `wr_busy` for exactly `WR_CYCLES` system clocks.
- R6: While `wr_busy` is high the target gives no acknowledge to anything. After `wr_busy` falls, a START followed by a matching slave byte is acknowledged again.
- R7: In a read, bit 0 of the slave byte is 1 and bit 1 sets register-address bit 8. Data bits are sent MSB first. The pointer steps forward once for each byte sent, and it wraps from 0x1FF to 0x000.
- R8: After an ACK from the host, the next byte follows. After a NACK, SDA stays released until a START or STOP.
- R9: A read with no address byte starts at the pointer. After a write, the pointer holds the address that was written. After a read, it holds the address that follows the last byte sent.
- R10: `sda_oe` changes only while SCL is low.
- R11: Out of reset, `sda_oe` and `wr_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| bus_strap | input | 2 | Strap pins matched against slave byte bits 3..2 |
| sda_oe | output | 1 | 1 pulls the SDA pad low |
| wr_busy | output | 1 | Write cycle in progress |

## Verification
A host may send a STOP or a new START on the same cycle that the write cycle is starting or running. If that stop is taken as a second commit, it restarts the timer. If the start is taken, the target answers while it should be deaf. The bench sends a full poll (START, slave byte, STOP) within the first few hundred clocks after each committing STOP. It then requires that the poll gets a NACK, that the pulse length measured on `wr_busy` equals `WR_CYCLES` exactly, and that a poll made after the pulse is acknowledged.

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [3:0] DEV_TYPE  = 4'b1001,
  parameter int         WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] bus_strap,
  output logic       sda_oe,
  output logic       wr_busy
);
  localparam int BW = $clog2(WR_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_WA, S_AACK, S_WD, S_WACK, S_WSTOP, S_RD, S_RACK, S_IGN
  } st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, wdat;
  logic [8:0] ptr;
  logic       rw, mack;
  logic [BW-1:0] bcnt;
  logic [7:0] mem [0:511];

  wire scl_s     = scl_m[1];
  wire sda_s     = sda_m[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] rd  = mem[ptr];
  wire commit    = ~wr_busy & stop_det & (st == S_WSTOP);
  wire rx_st     = (st == S_DEV) || (st == S_WA) || (st == S_WD);

  assign wr_busy = (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i}; sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s; sda_q <= sda_s;
    end

  always_ff @(posedge clk)
    if (commit) mem[ptr] <= wdat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; wdat <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; bcnt <= '0; sda_oe <= 1'b0;
    end else if (wr_busy) begin
      bcnt <= bcnt - 1'b1; st <= S_IDLE; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      if (commit) bcnt <= BW'(WR_CYCLES);
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (rx_st) begin
      if (scl_rise && cnt != 4'd8) begin
        sh <= {sh[6:0], sda_s}; cnt <= cnt + 1'b1;
      end else if (scl_fall && cnt == 4'd8) begin
        cnt <= '0;
        case (st)
          S_DEV:
            if (sh[7:4] == DEV_TYPE && sh[3:2] == bus_strap) begin
              sda_oe <= 1'b1; st <= S_DACK; rw <= sh[0]; ptr[8] <= sh[1];
            end else st <= S_IGN;
          S_WA:    begin ptr[7:0] <= sh; sda_oe <= 1'b1; st <= S_AACK; end
          default: begin wdat <= sh; sda_oe <= 1'b1; st <= S_WACK; end
        endcase
      end
    end else begin
      case (st)
        S_DACK: if (scl_fall) begin
          if (rw) begin
            tx <= {rd[6:0], 1'b0}; sda_oe <= ~rd[7]; ptr <= ptr + 1'b1;
            cnt <= 4'd1; st <= S_RD;
          end else begin
            sda_oe <= 1'b0; st <= S_WA;
          end
        end
        S_AACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WD; end
        S_WACK: if (scl_fall) begin sda_oe <= 1'b0; st <= S_WSTOP; end
        S_RD: if (scl_fall) begin
          if (cnt == 4'd8) begin sda_oe <= 1'b0; st <= S_RACK; end
          else begin sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 1'b1; end
        end
        S_RACK:
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              tx <= {rd[6:0], 1'b0}; sda_oe <= ~rd[7]; ptr <= ptr + 1'b1;
              cnt <= 4'd1; st <= S_RD;
            end else st <= S_IGN;
          end
        default: ;
      endcase
    end

  a_r6_silent_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !sda_oe);
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  a_r5_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(stop_det));
  a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> !sda_oe);
endmodule

// File: tb/tb_i2c_cfg_target.sv
module tb_i2c_cfg_target;
  localparam int WRC = 300;
  localparam int Q   = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, wr_busy;
  wire  sda = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_cfg_target #(.DEV_TYPE(4'b1001), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .bus_strap(strap),
    .sda_oe(sda_oe), .wr_busy(wr_busy));

  int total = 0, bad = 0, run = 0, last_len = 0, viol = 0;
  bit done = 0;
  logic [7:0] model [0:511];
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (wr_busy) run++;
    else if (run != 0) begin last_len = run; run = 0; end
    if (rst_n && sda_oe !== prev_oe && scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic tick(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; tick(); scl = 1; tick(); sda_m = 0; tick(); scl = 0; tick(); endtask
  task automatic i2c_stop(); sda_m = 0; tick(); scl = 1; tick(); sda_m = 1; tick(); tick(); endtask
  task automatic wbit(input bit b); sda_m = b; tick(); scl = 1; tick(); tick(); scl = 0; tick(); endtask
  task automatic rbit(output bit b); sda_m = 1; tick(); scl = 1; tick(); b = sda; tick(); scl = 0; tick(); endtask

  task automatic send(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(x); ack = !x;
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    bit x;
    for (int i = 7; i >= 0; i--) begin rbit(x); b[i] = x; end
    wbit(!mack);
  endtask

  function automatic logic [7:0] sb(input bit rw, input bit msb);
    return {4'b1001, strap, msb, rw};
  endfunction

  task automatic write_poll(input logic [8:0] a, input logic [7:0] d);
    bit ak;
    i2c_start();
    send(sb(0, a[8]), ak); chk(ak, "R3 slave ack", ak, 1);
    send(a[7:0], ak);      chk(ak, "R3 addr ack", ak, 1);
    send(d, ak);           chk(ak, "R3 data ack", ak, 1);
    i2c_stop(); model[a] = d;
    chk(wr_busy, "R5 busy after stop", wr_busy, 1);
    i2c_start(); send(sb(0, 0), ak); i2c_stop();
    chk(!ak, "R6 nack while busy", ak, 0);
    wait (!wr_busy); tick();
    chk(last_len == WRC, "R5 busy length", last_len, WRC);
    i2c_start(); send(sb(0, 0), ak); i2c_stop();
    chk(ak, "R6 ack after busy", ak, 1);
    chk(!wr_busy, "R4 no commit without data", wr_busy, 0);
  endtask

  task automatic rand_read(input logic [8:0] a, input int n);
    bit ak; logic [7:0] b;
    i2c_start(); send(sb(0, a[8]), ak); send(a[7:0], ak);
    i2c_start(); send(sb(1, a[8]), ak);
    chk(ak, "R1 repeated start ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv(k < n - 1, b);
      chk(b === model[9'(a + k)], "R7 read data", b, model[9'(a + k)]);
    end
    i2c_stop();
  endtask

  task automatic cur_read(input bit msb, input logic [8:0] exp_a);
    bit ak; logic [7:0] b;
    i2c_start(); send(sb(1, msb), ak); recv(0, b); i2c_stop();
    chk(b === model[exp_a], "R9 current read", b, model[exp_a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ak, x; logic [7:0] b; int hi;
    repeat (3) @(negedge clk);
    chk(!sda_oe && !wr_busy, "R11 reset outputs", {sda_oe, wr_busy}, 0);
    rst_n = 1; tick();

    for (int t = 0; t < 16; t++)
      for (int s = 0; s < 4; s++) begin
        i2c_start(); send({4'(t), 2'(s), 2'b00}, ak); i2c_stop();
        chk(ak == (t == 9 && s == strap), "R2 slave match", ak, (t == 9 && s == strap));
        chk(!wr_busy, "R4 stop before data", wr_busy, 0);
      end

    i2c_start(); send(8'h50, ak); send(sb(0, 0), ak); i2c_stop();
    chk(!ak, "R2 ignore after mismatch", ak, 0);

    write_poll(9'h000, 8'h3C);
    write_poll(9'h001, 8'hC5);
    write_poll(9'h0FF, 8'h81);
    write_poll(9'h100, 8'h5A);
    write_poll(9'h1FF, 8'hE7);
    write_poll(9'h0A5, 8'h96);

    cur_read(0, 9'h0A5);
    rand_read(9'h1FF, 2);
    cur_read(0, 9'h001);
    rand_read(9'h0FF, 2);
    rand_read(9'h000, 2);

    i2c_start(); send(sb(0, 1), ak); send(8'h00, ak); send(8'h77, ak);
    i2c_start(); i2c_stop(); tick();
    chk(!wr_busy, "R4 repeated start drops write", wr_busy, 0);
    rand_read(9'h100, 1);

    i2c_start(); send(sb(0, 0), ak); send(8'hA5, ak);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    i2c_stop(); tick();
    chk(!wr_busy, "R4 stop mid byte", wr_busy, 0);
    rand_read(9'h0A5, 1);

    i2c_start(); send(sb(1, 0), ak); recv(0, b);
    hi = 0;
    for (int i = 0; i < 9; i++) begin rbit(x); hi += x; end
    i2c_stop();
    chk(hi == 9, "R8 released after nack", hi, 9);

    chk(viol == 0, "R10 sda_oe changes with scl high", viol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule